// File: doc/BRIEF.md
# Whole-Packet Source Injector

This block sits at the source end of a one-dimensional bypass network. The local core writes a packet into it one flit at a time. The first write of a packet also gives the packet length, the destination position along the dimension and a virtual channel. The unit holds the packet in a local store until every flit has arrived. It launches nothing before that point.

Once the packet is complete, the unit waits for the output side to say that it is free. The output side drives this signal high only when the next node can take the entire packet, as virtual cut-through requires. When the signal is high, the unit streams the flits out on back-to-back cycles. Every flit carries a bypass request with two fields:
- the distance still to travel, in hops;
- the virtual channel, which was fixed at the source.

The cycle after the last flit, the unit pulses a completion flag and accepts the next packet.

Top module: `inj_source_unit`

## Requirements
- R1: After reset, `flit_valid` and `done` are low and `wr_ready` is high.
- R2: No flit is emitted while a packet is only partly written, even when `out_free` is high and even with idle gaps between writes.
- R3: With a complete packet held and `out_free` low, no flit is emitted and `wr_ready` stays low. The first flit appears in the cycle after the first clock edge at which `out_free` is high.
- R4: A launched packet leaves as exactly `len` flits on consecutive cycles, in write order. `flit_head` is high on the first flit only and `flit_tail` on the last flit only.
- R5: `req_vc` equals the `wr_vc` given with the head write, on every flit of the packet.
- R6: `req_hops` equals |`wr_dst` − SRC_POS| on every flit of the packet.
- R7: `done` is a one-cycle pulse in the cycle after the tail flit. In that same cycle `flit_valid` is low and `wr_ready` is high.
- R8: Once a packet has started, dropping `out_free` neither breaks nor shortens the flit stream.
- R9: Writes are ignored in three cases: a write without `wr_head` while idle, and any write while a packet waits for launch or is being sent. Ignored writes do not change the flits of the buffered packet.
- R10: A length field of 0 is treated as 1. A length field above MAX_FLITS is treated as MAX_FLITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Flit write strobe from the core |
| wr_head | input | 1 | Marks the first flit of a packet |
| wr_data | input | DATA_W | Flit payload |
| wr_len | input | LEN_W | Packet length in flits, sampled with the head |
| wr_dst | input | POS_W | Destination position, sampled with the head |
| wr_vc | input | VC_W | Virtual channel, sampled with the head |
| wr_ready | output | 1 | Unit accepts writes |
| out_free | input | 1 | Output and downstream room for a whole packet available |
| flit_valid | output | 1 | Flit on the output this cycle |
| flit_head | output | 1 | First flit of the packet |
| flit_tail | output | 1 | Last flit of the packet |
| flit_data | output | DATA_W | Flit payload |
| req_hops | output | POS_W | Bypass request: hops left |
| req_vc | output | VC_W | Bypass request: virtual channel |
| done | output | 1 | Packet fully sent (one-cycle pulse) |

## Verification
Two situations are hard to produce from the ports. The first is a packet that is complete but held back. To get there, the bench keeps `out_free` low across the final write and for several cycles after it. During that hold it also writes a new head flit, which must be dropped. The second is a stream that must not break. To get there, the bench pulls `out_free` low right after the head flit leaves. In both cases the flit data that comes out shows whether the buffer was left untouched.

// File: rtl/inj_pkg.sv
package inj_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_READY = 2'd2,
        ST_SEND  = 2'd3
    } inj_state_e;
endpackage

// File: rtl/inj_pkt_buf.sv
module inj_pkt_buf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/inj_hop_calc.sv
module inj_hop_calc #(
    parameter int POS_W   = 4,
    parameter int SRC_POS = 5
) (
    input  logic [POS_W-1:0] dst,
    output logic [POS_W-1:0] hops
);
    localparam logic [POS_W-1:0] SRC = POS_W'(SRC_POS);

    always_comb begin
        if (dst >= SRC) begin
            hops = dst - SRC;
        end else begin
            hops = SRC - dst;
        end
    end
endmodule

// File: rtl/inj_source_unit.sv
module inj_source_unit
    import inj_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_FLITS = 8,
    parameter int POS_W     = 4,
    parameter int VC_NUM    = 4,
    parameter int SRC_POS   = 5,
    localparam int IDX_W = (MAX_FLITS > 1) ? $clog2(MAX_FLITS) : 1,
    localparam int LEN_W = $clog2(MAX_FLITS + 1),
    localparam int VC_W  = (VC_NUM > 1) ? $clog2(VC_NUM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_head,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [POS_W-1:0]  wr_dst,
    input  logic [VC_W-1:0]   wr_vc,
    output logic              wr_ready,
    input  logic              out_free,
    output logic              flit_valid,
    output logic              flit_head,
    output logic              flit_tail,
    output logic [DATA_W-1:0] flit_data,
    output logic [POS_W-1:0]  req_hops,
    output logic [VC_W-1:0]   req_vc,
    output logic              done
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_FLITS);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        inj_state_e       state;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [POS_W-1:0] dst;
        logic [VC_W-1:0]  vc;
        logic             done;
    } inj_regs_t;

    inj_regs_t        r_d, r_q;
    logic             buf_we;
    logic [IDX_W-1:0] buf_waddr;
    logic [LEN_W-1:0] len_fix;
    logic [LEN_W-1:0] cnt_inc;

    always_comb begin
        if (wr_len == '0) begin
            len_fix = LEN_ONE;
        end else if (wr_len > LEN_MAX) begin
            len_fix = LEN_MAX;
        end else begin
            len_fix = wr_len;
        end
    end

    assign cnt_inc = r_q.cnt + LEN_ONE;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        buf_we    = 1'b0;
        buf_waddr = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (wr_valid && wr_head) begin
                    buf_we    = 1'b1;
                    r_d.len   = len_fix;
                    r_d.dst   = wr_dst;
                    r_d.vc    = wr_vc;
                    r_d.cnt   = LEN_ONE;
                    r_d.state = (len_fix == LEN_ONE) ? ST_READY : ST_FILL;
                end
            end
            ST_FILL: begin
                if (wr_valid) begin
                    buf_we    = 1'b1;
                    buf_waddr = r_q.cnt[IDX_W-1:0];
                    r_d.cnt   = cnt_inc;
                    if (cnt_inc == r_q.len) begin
                        r_d.state = ST_READY;
                    end
                end
            end
            ST_READY: begin
                if (out_free) begin
                    r_d.state = ST_SEND;
                    r_d.cnt   = '0;
                end
            end
            ST_SEND: begin
                if (cnt_inc == r_q.len) begin
                    r_d.state = ST_IDLE;
                    r_d.cnt   = '0;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, len: LEN_ONE, dst: '0, vc: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    inj_pkt_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (MAX_FLITS)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_addr (buf_waddr),
        .wr_data (wr_data),
        .rd_addr (r_q.cnt[IDX_W-1:0]),
        .rd_data (flit_data)
    );

    inj_hop_calc #(
        .POS_W   (POS_W),
        .SRC_POS (SRC_POS)
    ) u_hops (
        .dst  (r_q.dst),
        .hops (req_hops)
    );

    assign wr_ready   = (r_q.state == ST_IDLE) || (r_q.state == ST_FILL);
    assign flit_valid = (r_q.state == ST_SEND);
    assign flit_head  = flit_valid && (r_q.cnt == '0);
    assign flit_tail  = flit_valid && (cnt_inc == r_q.len);
    assign req_vc     = r_q.vc;
    assign done       = r_q.done;

    // R2
    no_early_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flit_valid) |-> $past(r_q.state == ST_READY));

    // R3
    launch_needs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flit_valid) |-> $past(out_free));

    // R4
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !flit_tail) |=> flit_valid);

    // R5
    vc_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !flit_tail) |=> $stable(req_vc) && $stable(req_hops));

    // R7
    done_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && flit_tail) |=> (done && !flit_valid));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/inj_source_unit_test.sv
module inj_source_unit_test;
    localparam int DATA_W = 16;
    localparam int MAXF   = 8;
    localparam int POS_W  = 4;
    localparam int VC_W   = 2;
    localparam int LEN_W  = 4;
    localparam int SRC    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic              wr_head = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [LEN_W-1:0]  wr_len = '0;
    logic [POS_W-1:0]  wr_dst = '0;
    logic [VC_W-1:0]   wr_vc = '0;
    logic              wr_ready;
    logic              out_free = 1'b1;
    logic              flit_valid, flit_head, flit_tail, done;
    logic [DATA_W-1:0] flit_data;
    logic [POS_W-1:0]  req_hops;
    logic [VC_W-1:0]   req_vc;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    inj_source_unit #(
        .DATA_W(DATA_W), .MAX_FLITS(MAXF), .POS_W(POS_W), .VC_NUM(4), .SRC_POS(SRC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_head(wr_head),
        .wr_data(wr_data), .wr_len(wr_len), .wr_dst(wr_dst), .wr_vc(wr_vc),
        .wr_ready(wr_ready), .out_free(out_free), .flit_valid(flit_valid),
        .flit_head(flit_head), .flit_tail(flit_tail), .flit_data(flit_data),
        .req_hops(req_hops), .req_vc(req_vc), .done(done)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int hops_of(int dst);
        return (dst >= SRC) ? dst - SRC : SRC - dst;
    endfunction

    // writes nflits flits with gap idle cycles between them
    task automatic wr_pkt(int nflits, int len_field, int dst, int vc, int base, int gap);
        for (int i = 0; i < nflits; i++) begin
            @(negedge clk);
            if (i > 0) chk("R2 no flit while filling", flit_valid, 0);
            wr_valid = 1'b1;
            wr_head  = (i == 0);
            wr_data  = DATA_W'(base + i);
            wr_len   = LEN_W'(len_field);
            wr_dst   = POS_W'(dst);
            wr_vc    = VC_W'(vc);
            if (gap > 0 && i < nflits - 1) begin
                @(negedge clk);
                wr_valid = 1'b0;
                for (int g = 1; g < gap; g++) begin
                    @(negedge clk);
                    chk("R2 no flit during write gap", flit_valid, 0);
                end
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;
        wr_head  = 1'b0;
    endtask

    // expects the first flit one sample later; optionally drops out_free after the head
    task automatic rx_pkt(int len, int dst, int vc, int base, bit drop_free);
        int wait_n = 0;
        while (!flit_valid && wait_n < 20) begin
            @(negedge clk);
            wait_n++;
        end
        chk("R3 launch one cycle after free", wait_n, 1);
        for (int i = 0; i < len; i++) begin
            if (i > 0) @(negedge clk);
            chk("R4 flit valid", flit_valid, 1);
            chk("R4 flit order", int'(flit_data), (base + i) & 16'hFFFF);
            chk("R4 head flag", flit_head, (i == 0));
            chk("R4 tail flag", flit_tail, (i == len - 1));
            chk("R5 vc", req_vc, vc);
            chk("R6 hops", req_hops, hops_of(dst));
            if (drop_free && i == 0) out_free = 1'b0;
        end
        @(negedge clk);
        chk("R7 done pulse", done, 1);
        chk("R7 idle after tail", flit_valid, 0);
        chk("R7 ready after tail", wr_ready, 1);
        @(negedge clk);
        chk("R7 done is one cycle", done, 0);
        out_free = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 flit_valid", flit_valid, 0);
        chk("R1 done", done, 0);
        chk("R1 wr_ready", wr_ready, 1);
    endtask

    task automatic t_basic();
        out_free = 1'b1;
        wr_pkt(4, 4, 9, 2, 16'h100, 0);
        rx_pkt(4, 9, 2, 16'h100, 1'b0);
    endtask

    task automatic t_gapped();
        out_free = 1'b1;
        wr_pkt(5, 5, 14, 3, 16'h200, 3);
        rx_pkt(5, 14, 3, 16'h200, 1'b0);
    endtask

    task automatic t_hold();
        out_free = 1'b0;
        wr_pkt(3, 3, 2, 1, 16'h300, 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R3 held no flit", flit_valid, 0);
            chk("R3 held not ready", wr_ready, 0);
            wr_valid = 1'b1;
            wr_head  = 1'b1;
            wr_data  = 16'hBEEF;
            wr_len   = 4'd2;
        end
        @(negedge clk);
        wr_valid = 1'b0;
        wr_head  = 1'b0;
        out_free = 1'b1;
        rx_pkt(3, 2, 1, 16'h300, 1'b0);  // R9 held writes dropped
    endtask

    task automatic t_nobreak();
        out_free = 1'b1;
        wr_pkt(6, 6, 0, 0, 16'h400, 0);
        rx_pkt(6, 0, 0, 16'h400, 1'b1);  // R8
    endtask

    task automatic t_idle_nonhead();
        @(negedge clk);
        wr_valid = 1'b1;
        wr_head  = 1'b0;
        wr_data  = 16'hDEAD;
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R9 non-head idle write no flit", flit_valid, 0);
        out_free = 1'b1;
        wr_pkt(2, 2, 7, 1, 16'h500, 0);
        rx_pkt(2, 7, 1, 16'h500, 1'b0);  // R9
    endtask

    task automatic t_lengths();
        out_free = 1'b1;
        wr_pkt(1, 1, 5, 2, 16'h600, 0);
        rx_pkt(1, 5, 2, 16'h600, 1'b0);  // single flit, zero hops
        wr_pkt(1, 0, 3, 3, 16'h700, 0);
        rx_pkt(1, 3, 3, 16'h700, 1'b0);  // R10 zero length
        wr_pkt(8, 15, 12, 1, 16'h800, 0);
        rx_pkt(8, 12, 1, 16'h800, 1'b0); // R10 oversize length
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_gapped();
        t_hold();
        t_nobreak();
        t_idle_nonhead();
        t_lengths();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule